// File: doc/BRIEF.md
# Double-Buffered PWM Compare Unit

This block keeps the two compare values, A and B, that a PWM time-base counter is matched against. Each channel has an active value, which the compare uses, and a pending (shadow) value, which software writes. A per-channel mode bit selects between buffered operation and direct operation. In buffered operation, a bus write only updates the pending value. The pending value moves into the active register when a chosen counter event occurs: the counter reaching zero, the counter reaching the period, either of the two, or never. In direct operation, a bus write updates the active register and the compare uses it at once.

Software uses a simple register bus. Writes are offered with `wr_valid` and accepted through `wr_ready`. The block never applies back-pressure, so `wr_ready` stays high and a write is taken in every cycle that `wr_valid` is high. Reads are combinational from `rd_addr`. The counter value and the period come from the external time base. The block outputs one compare-equal strobe per channel and one pending-full flag per channel. Channel A also holds a fine-resolution extension field. That field is buffered together with the main value, but a write to the extension alone does not mark the channel as pending.

Register word addresses (`wr_addr`/`rd_addr`):

| Address | Contents |
|---------|----------|
| 0 | control word |
| 1 | A main value, in bits [15:0] |
| 2 | A extension, in bits [7:0] |
| 3 | A combined: main value in bits [31:16], extension in bits [7:0] |
| 4 | B value, in bits [15:0] |

Top module: `pwm_cmp_dbuf`

## Requirements
- R1: After reset, the control word, both active values, both pending values and both full flags are zero. Every register reads 0.
- R2: Control word layout. Bit 9 is the B full flag and bit 8 is the A full flag; both are read-only. Bit 6 is the B mode and bit 4 is the A mode (1 = direct). Bits 3:2 are the B load select and bits 1:0 are the A load select. Every other bit reads as 0, so writing 0xFFFF with no flag set reads back 0x005F.
- R3: In buffered mode, a write changes only the pending value. A read of the value returns the active value.
- R4: Load select 00 copies the pending value into the active register at the clock edge that ends a cycle in which the counter equals 0.
- R5: Load select 01 copies the pending value at the edge that ends a cycle in which the counter equals the period, and not on counter equals 0.
- R6: Load select 10 copies on either event. When the counter equals 0 and also equals the period in the same cycle, exactly one copy occurs and the flag clears.
- R7: Load select 11 freezes the channel. No copy ever happens, and the flag stays set.
- R8: In direct mode, a write reaches the active value by the next cycle, and the compare uses it. The load select has no effect, and the full flag is not set.
- R9: A buffered write sets the channel's full flag, which `full_a`/`full_b` mirror. A copy clears the flag.
- R10: A write while the flag is set is accepted and replaces the pending value.
- R11: On channel A, a write to address 1 or address 3 sets the flag. A write to address 2 alone leaves the flag unchanged, but it still updates the pending extension.
- R12: A write in the same cycle as a copy lands in the pending register. The active register takes the old pending value, and the flag ends that cycle set.
- R13: `eq_a`/`eq_b` are high in exactly the cycles where the counter equals the channel's active main value.
- R14: `wr_ready` is always high, so writes are never stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_valid | input | 1 | write offered this cycle |
| wr_ready | output | 1 | write accepted (always 1) |
| wr_addr | input | 3 | write word address |
| wr_data | input | 32 | write data |
| rd_addr | input | 3 | read word address |
| rd_data | output | 32 | read data, combinational |
| ctr | input | CW | time-base counter value |
| prd | input | CW | time-base period |
| eq_a | output | 1 | counter equals A active value |
| eq_b | output | 1 | counter equals B active value |
| full_a | output | 1 | A pending value not yet copied |
| full_b | output | 1 | B pending value not yet copied |

## Verification
A wrong load decode shows up in the first cycle after the counter event. The read-back of the active value is then stale or changed too early, and the full flag fails to drop. A corrupted pending register stays hidden until the next copy, so the bench always performs a copy and reads back the result. A wrong mode or flag bit shows up at once on `full_a`/`full_b` and in the control word. A wrong active value also moves the compare strobe to a different counter value.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [2:0] {
    ADDR_CTL    = 3'd0,
    ADDR_A_MAIN = 3'd1,
    ADDR_A_HR   = 3'd2,
    ADDR_A_BOTH = 3'd3,
    ADDR_B      = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PERIOD = 2'b01,
    LD_EITHER = 2'b10,
    LD_FREEZE = 2'b11
  } ld_sel_e;

  localparam int NCH = 2;
endpackage

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg import pwm_cmp_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NCH-1:0]      wr_mode,
  input  logic [NCH-1:0][1:0] wr_sel,
  output logic [NCH-1:0]      mode_q,
  output logic [NCH-1:0][1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      mode_q <= wr_mode;
      sel_q  <= wr_sel;
    end
  end
endmodule

// File: rtl/cmp_load_sel.sv
module cmp_load_sel import pwm_cmp_pkg::*; (
  input  logic [1:0] sel,
  input  logic       at_zero,
  input  logic       at_prd,
  output logic       evt
);
  always_comb begin
    unique case (ld_sel_e'(sel))
      LD_ZERO:   evt = at_zero;
      LD_PERIOD: evt = at_prd;
      LD_EITHER: evt = at_zero | at_prd;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         imm,
  input  logic         load_evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_val,
  input  logic         set_flag,
  output logic [W-1:0] act_q,
  output logic         full_q
);
  logic [W-1:0] shd_q;
  logic         do_load;

  assign do_load = load_evt & ~imm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      shd_q  <= '0;
      full_q <= 1'b0;
    end else if (imm) begin
      if (wr_en) act_q <= (act_q & ~wr_mask) | (wr_val & wr_mask);
    end else begin
      if (do_load) act_q <= shd_q;
      if (wr_en)   shd_q <= (shd_q & ~wr_mask) | (wr_val & wr_mask);
      if (wr_en && set_flag) full_q <= 1'b1;
      else if (do_load)      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_cmp_dbuf.sv
module pwm_cmp_dbuf import pwm_cmp_pkg::*; #(
  parameter int CW  = 16,
  parameter int HRW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_addr,
  output logic [31:0]   rd_data,
  input  logic [CW-1:0] ctr,
  input  logic [CW-1:0] prd,
  output logic          eq_a,
  output logic          eq_b,
  output logic          full_a,
  output logic          full_b
);
  localparam int WA = CW + HRW;

  logic [NCH-1:0]      mode_q;
  logic [NCH-1:0][1:0] sel_q;
  logic [NCH-1:0]      ld_evt;
  logic                at_zero, at_prd;

  logic [WA-1:0]  act_a, mask_a, val_a;
  logic           wen_a, setf_a;
  logic [CW-1:0]  act_b;
  logic           wen_b;
  logic [CW-1:0]  a_main;
  logic [HRW-1:0] a_hr;

  assign wr_ready = 1'b1;
  assign at_zero  = (ctr == '0);
  assign at_prd   = (ctr == prd);

  cmp_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid && wr_addr == ADDR_CTL),
    .wr_mode ({wr_data[6], wr_data[4]}),
    .wr_sel  ({wr_data[3:2], wr_data[1:0]}),
    .mode_q  (mode_q),
    .sel_q   (sel_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ld
    cmp_load_sel u_ld (
      .sel     (sel_q[g]),
      .at_zero (at_zero),
      .at_prd  (at_prd),
      .evt     (ld_evt[g])
    );
  end

  always_comb begin
    wen_a  = wr_valid && (wr_addr == ADDR_A_MAIN || wr_addr == ADDR_A_HR ||
                          wr_addr == ADDR_A_BOTH);
    setf_a = (wr_addr != ADDR_A_HR);
    mask_a = '0;
    val_a  = {wr_data[CW-1:0], wr_data[HRW-1:0]};
    unique case (wr_addr)
      ADDR_A_MAIN: mask_a = {{CW{1'b1}}, {HRW{1'b0}}};
      ADDR_A_HR:   mask_a = {{CW{1'b0}}, {HRW{1'b1}}};
      ADDR_A_BOTH: begin
        mask_a = '1;
        val_a  = {wr_data[16+CW-1:16], wr_data[HRW-1:0]};
      end
      default:     mask_a = '0;
    endcase
    wen_b = wr_valid && (wr_addr == ADDR_B);
  end

  cmp_channel #(.W(WA)) u_ch_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm      (mode_q[0]),
    .load_evt (ld_evt[0]),
    .wr_en    (wen_a),
    .wr_mask  (mask_a),
    .wr_val   (val_a),
    .set_flag (setf_a),
    .act_q    (act_a),
    .full_q   (full_a)
  );

  cmp_channel #(.W(CW)) u_ch_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm      (mode_q[1]),
    .load_evt (ld_evt[1]),
    .wr_en    (wen_b),
    .wr_mask  ({CW{1'b1}}),
    .wr_val   (wr_data[CW-1:0]),
    .set_flag (1'b1),
    .act_q    (act_b),
    .full_q   (full_b)
  );

  assign a_main = act_a[WA-1:HRW];
  assign a_hr   = act_a[HRW-1:0];
  assign eq_a   = (ctr == a_main);
  assign eq_b   = (ctr == act_b);

  always_comb begin
    unique case (rd_addr)
      ADDR_CTL:    rd_data = {22'b0, full_b, full_a, 1'b0, mode_q[1], 1'b0,
                              mode_q[0], sel_q[1], sel_q[0]};
      ADDR_A_MAIN: rd_data = 32'(a_main);
      ADDR_A_HR:   rd_data = 32'(a_hr);
      ADDR_A_BOTH: rd_data = (32'(a_main) << 16) | 32'(a_hr);
      ADDR_B:      rd_data = 32'(act_b);
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_cmp_chk.sv
module pwm_cmp_chk import pwm_cmp_pkg::*; #(
  parameter int CW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic [2:0]          wr_addr,
  input logic [CW-1:0]       ctr,
  input logic [CW-1:0]       prd,
  input logic [NCH-1:0]      mode,
  input logic [NCH-1:0][1:0] sel,
  input logic [CW-1:0]       act_a_main,
  input logic [CW-1:0]       act_b,
  input logic                full_a,
  input logic                full_b
);
  logic wr_any_a, wr_b;
  assign wr_any_a = wr_valid && (wr_addr == ADDR_A_MAIN || wr_addr == ADDR_A_HR ||
                                 wr_addr == ADDR_A_BOTH);
  assign wr_b     = wr_valid && (wr_addr == ADDR_B);

  AST_MAIN_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && wr_valid && (wr_addr == ADDR_A_MAIN || wr_addr == ADDR_A_BOTH)) |=> full_a); // R11

  AST_HR_WR_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && sel[0] == LD_FREEZE && wr_valid && wr_addr == ADDR_A_HR) |=> (full_a == $past(full_a))); // R11

  AST_FREEZE_HOLDS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && sel[0] == LD_FREEZE && !wr_any_a) |=> $stable(act_a_main)); // R7

  AST_ZERO_LOAD_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && sel[1] == LD_ZERO && ctr == '0 && !wr_b) |=> !full_b); // R4

  AST_PERIOD_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && sel[1] == LD_PERIOD && ctr != prd && !wr_b) |=> $stable(act_b)); // R5

  AST_DIRECT_NO_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !full_b) |=> !full_b); // R8
endmodule

bind pwm_cmp_dbuf pwm_cmp_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .ctr        (ctr),
  .prd        (prd),
  .mode       (mode_q),
  .sel        (sel_q),
  .act_a_main (a_main),
  .act_b      (act_b),
  .full_a     (full_a),
  .full_b     (full_b)
);

// File: tb/tb_pwm_cmp_dbuf.sv
module tb_pwm_cmp_dbuf;
  localparam int CW = 16;
  localparam int HRW = 8;
  localparam logic [15:0] CTR_IDLE = 16'd5;
  localparam logic [15:0] PRD_DEF = 16'd100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [CW-1:0] ctr = CTR_IDLE;
  logic [CW-1:0] prd = PRD_DEF;
  logic eq_a, eq_b, full_a, full_b;

  always #5 clk = ~clk;

  pwm_cmp_dbuf #(.CW(CW), .HRW(HRW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctr(ctr), .prd(prd), .eq_a(eq_a), .eq_b(eq_b), .full_a(full_a), .full_b(full_b)
  );

  // kind: 0 = rd_data, 1 = {full_b,full_a}, 2 = {eq_b,eq_a}, 3 = wr_ready
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = rd_data;
        1: act = {30'b0, full_b, full_a};
        2: act = {30'b0, eq_b, eq_a};
        default: act = {31'b0, wr_ready};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wr_at(input logic [2:0] a, input logic [31:0] d, input logic [15:0] c);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; ctr = c;
    step();
    wr_valid = 1'b0; ctr = CTR_IDLE;
  endtask

  task automatic pulse(input logic [15:0] c);
    ctr = c;
    step();
    ctr = CTR_IDLE;
  endtask

  task automatic expect_item(input int k, input logic [2:0] a, input logic [31:0] e, input string r);
    item_t it;
    rd_addr = a;
    it.kind = k; it.exp = e; it.req = r;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string r);
    expect_item(0, a, e, r);
  endtask

  task automatic chk_flags(input logic [1:0] e, input string r);
    expect_item(1, rd_addr, {30'b0, e}, r);
  endtask

  task automatic chk_eq(input logic [1:0] e, input string r);
    expect_item(2, rd_addr, {30'b0, e}, r);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk_rd(3'd0, 32'h0, "R1 ctl");
    chk_rd(3'd3, 32'h0, "R1 A combined");
    chk_rd(3'd4, 32'h0, "R1 B");
    chk_flags(2'b00, "R1 flags");
    // R2 layout, reserved bits read zero
    step(); wr(3'd0, 32'h0000_FFFF);
    chk_rd(3'd0, 32'h0000_005F, "R2 ctl readback");
    step(); wr(3'd0, 32'h0);
    // R3, R9 buffered write
    wr(3'd1, 32'h1234);
    chk_rd(3'd1, 32'h0, "R3 active unchanged");
    chk_flags(2'b01, "R9 flag set");
    chk_rd(3'd0, 32'h0000_0100, "R2 A flag bit 8");
    // R10 overwrite, R4 zero load
    step(); wr(3'd1, 32'h2222);
    pulse(16'h0000);
    chk_rd(3'd1, 32'h2222, "R10 R4 latest pending loaded");
    chk_flags(2'b00, "R9 flag cleared");
    // R13 compare strobe
    ctr = 16'h2222;
    chk_eq(2'b01, "R13 eq_a at match");
    ctr = CTR_IDLE;
    chk_eq(2'b00, "R13 no match");
    // R5 period load
    step(); wr(3'd0, 32'h1);
    wr(3'd1, 32'h0033);
    pulse(16'h0000);
    chk_rd(3'd1, 32'h2222, "R5 no load on zero");
    chk_flags(2'b01, "R5 flag held");
    step(); pulse(PRD_DEF);
    chk_rd(3'd1, 32'h0033, "R5 load on period");
    chk_flags(2'b00, "R5 flag cleared");
    // R6 either
    step(); wr(3'd0, 32'h2);
    wr(3'd1, 32'h0044); pulse(16'h0000);
    chk_rd(3'd1, 32'h0044, "R6 load on zero");
    step(); wr(3'd1, 32'h0055); pulse(PRD_DEF);
    chk_rd(3'd1, 32'h0055, "R6 load on period");
    step(); prd = 16'h0000;
    wr(3'd1, 32'h0066); pulse(16'h0000);
    chk_rd(3'd1, 32'h0066, "R6 coincident events");
    chk_flags(2'b00, "R6 flag cleared once");
    prd = PRD_DEF;
    // R7 freeze
    step(); wr(3'd0, 32'h3);
    wr(3'd1, 32'h0077); pulse(16'h0000); pulse(PRD_DEF);
    chk_rd(3'd1, 32'h0066, "R7 frozen");
    chk_flags(2'b01, "R7 flag stays");
    // R11 extension writes
    step(); wr(3'd0, 32'h0);
    pulse(16'h0000);
    chk_rd(3'd1, 32'h0077, "R4 load after unfreeze");
    step(); wr(3'd2, 32'h00AB);
    chk_flags(2'b00, "R11 extension write keeps flag");
    step(); pulse(16'h0000);
    chk_rd(3'd2, 32'h00AB, "R11 extension loaded");
    step(); wr(3'd3, 32'h0099_00CD);
    chk_flags(2'b01, "R11 combined write sets flag");
    step(); pulse(16'h0000);
    chk_rd(3'd3, 32'h0099_00CD, "R11 combined loaded");
    // R12 write during load
    step(); wr(3'd4, 32'h0010);
    chk_flags(2'b10, "R9 B flag set");
    step(); wr_at(3'd4, 32'h0020, 16'h0000);
    chk_rd(3'd4, 32'h0010, "R12 active gets old pending");
    chk_flags(2'b10, "R12 flag ends set");
    step(); pulse(16'h0000);
    chk_rd(3'd4, 32'h0020, "R12 new value kept");
    chk_flags(2'b00, "R12 flag cleared");
    // R8 direct mode
    step(); wr(3'd0, 32'h40);
    wr(3'd4, 32'h0030);
    chk_rd(3'd4, 32'h0030, "R8 direct write");
    chk_flags(2'b00, "R8 no flag");
    ctr = 16'h0030;
    chk_eq(2'b10, "R8 R13 compare uses new value");
    ctr = CTR_IDLE;
    step(); wr(3'd0, 32'h4C);
    wr(3'd4, 32'h0031);
    chk_rd(3'd4, 32'h0031, "R8 select ignored");
    step(); pulse(16'h0000);
    chk_rd(3'd4, 32'h0031, "R8 no load in direct");
    chk_flags(2'b00, "R8 flags clear");
    // R14
    expect_item(3, rd_addr, 32'h1, "R14 ready high");
    step();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule